// File: doc/BRIEF.md
# Network Controller Command and Control Register File

This block is the host-visible register file of an Ethernet DMA controller. It holds 64 word-addressed 16-bit registers behind a simple synchronous host port (one write strobe, one address, registered read data one cycle after the address). Writes to the command register are decoded into one-cycle action pulses for the DMA engines. The engines report completion through done inputs, and each done input clears the matching command bit. Engines post events into an interrupt status register. A mask register gates that status onto a single interrupt line.

Every register has its own write rule. Some registers keep only certain bits. Some store the one's complement of the written value. Some are read-only. Some accept writes only while the controller is held in software reset. The status register is cleared by writing ones. A command register whose reset bit is still set treats the next command write that lacks the reset bit as a request to leave reset and nothing more.

The default layout places the command register at 0x00, the data configuration registers at 0x01 and 0x3F, receive and transmit control at 0x02 and 0x03, the interrupt mask and status at 0x04 and 0x05, the end-of-buffer count at 0x13, the ring pointers at 0x15 to 0x18, the CAM address ports at 0x22 to 0x24, CAM enable at 0x25, the revision register at 0x28, the sequence counter at 0x2B, the error tallies at 0x2C to 0x2E, and a read-only register at 0x2F.

Top module: `nic_cmd_regfile`

## Requirements
- R1: After hardware reset the command register (0x00) reads 0x0094, which is reset (bit 7), stop-timer (bit 4) and receive-disable (bit 2). Mask (0x04), status (0x05), second configuration (0x3F), sequence counter (0x2B) and CAM enable (0x25) read 0. End-of-buffer count (0x13) reads 0x02F8. `irq` and `cmd_pulse` are 0.
- R2: Bit 15 of the mask register is never stored. `irq` is high one cycle after the registered mask AND status is nonzero, and it is low otherwise.
- R3: A write to the status register clears exactly the bits that are written as 1 and are currently set. Bits raised on `stat_set` are ORed in during the same cycle, and a set takes priority over a clear.
- R4: A status write that clears bit 5 (buffers exhausted, 0x0020) makes `cmd_pulse` bit 8 (read resource) high for exactly the one cycle after the write. A status write that does not clear bit 5 gives no such pulse.
- R5: While command bit 7 is set, a command write whose bit 7 is 0 only clears bit 7. No other command bit changes and no pulse is issued.
- R6: Otherwise the written value ANDed with 0x03BF is ORed into the command register. That same masked value appears on `cmd_pulse` for exactly the one cycle after the write. Bit positions: 0 halt-tx, 1 transmit, 2 rx-disable, 3 rx-enable, 4 stop-timer, 5 start-timer, 7 reset, 8 read-resource, 9 load-CAM.
- R7: Writing rx-enable clears rx-disable, and writing rx-disable clears rx-enable. Writing start-timer clears stop-timer, and writing stop-timer clears start-timer.
- R8: A command write with bit 7 set first clears bits 9, 8, 1 and 0. It then ORs in the written bits, and it leaves bits 7 and 2 set.
- R9: `tx_done`, `rra_done` and `cam_done` clear command bits 1, 8 and 9 respectively. A command write in the same cycle that sets the bit wins.
- R10: The configuration register 0x01 stores the write AND 0xBFFF, and 0x3F stores the write AND 0xF017. Both accept a write only while command bit 7 is set. Writes at other times leave them unchanged.
- R11: The transmit control register (0x03) keeps only bits 15:12 of a write. The receive control register (0x02) stores the write AND 0xFFE0.
- R12: The ring pointers (0x15 to 0x18) store the write with bit 0 forced to 0. The tallies (0x2C to 0x2E) store the one's complement of the write.
- R13: The registers 0x22, 0x23, 0x24 and 0x2F read 0, and 0x28 reads 0x0004. Writes to any of them are ignored.
- R14: Every other register stores the full written word. `host_rdata` shows the register addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 6 | Word address of the register |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for the address of the previous cycle |
| tx_done | input | 1 | Transmit engine finished |
| rra_done | input | 1 | Resource-read engine finished |
| cam_done | input | 1 | CAM-load engine finished |
| stat_set | input | 16 | Event bits ORed into the status register |
| cmd_pulse | output | 16 | One-cycle action pulses, laid out as the command bits |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the reset-release write. A design that acted on the other bits of that write would pulse the transmit engine and set rx-enable while still leaving reset. It also targets the pairs of command bits that clear each other; getting these wrong leaves both rx-enable and rx-disable set. On the status register it checks clear-only-if-set, set-over-clear in the same cycle, and a read-resource pulse only when bit 5 actually falls. It checks reset-mode gating of both configuration registers in both directions. Random writes across the address map cover the masked, inverted and read-only registers, where a wrong mask or a missing inversion shows up directly on readback.

// File: rtl/nicreg_pkg.sv
package nicreg_pkg;
  localparam int DW = 16;
  localparam int AW = 6;

  localparam logic [AW-1:0] A_CMD    = 6'h00;
  localparam logic [AW-1:0] A_DCFG   = 6'h01;
  localparam logic [AW-1:0] A_RXCTL  = 6'h02;
  localparam logic [AW-1:0] A_TXCTL  = 6'h03;
  localparam logic [AW-1:0] A_IMASK  = 6'h04;
  localparam logic [AW-1:0] A_ISTAT  = 6'h05;
  localparam logic [AW-1:0] A_EOB    = 6'h13;
  localparam logic [AW-1:0] A_RING_LO = 6'h15;
  localparam logic [AW-1:0] A_RING_HI = 6'h18;
  localparam logic [AW-1:0] A_CAMP_LO = 6'h22;
  localparam logic [AW-1:0] A_CAMP_HI = 6'h24;
  localparam logic [AW-1:0] A_CAMEN  = 6'h25;
  localparam logic [AW-1:0] A_REV    = 6'h28;
  localparam logic [AW-1:0] A_SEQ    = 6'h2B;
  localparam logic [AW-1:0] A_TALLY_LO = 6'h2C;
  localparam logic [AW-1:0] A_TALLY_HI = 6'h2E;
  localparam logic [AW-1:0] A_ROSTAT = 6'h2F;
  localparam logic [AW-1:0] A_DCFG2  = 6'h3F;

  // command bit positions
  localparam int C_HALT  = 0;
  localparam int C_TX    = 1;
  localparam int C_RXDIS = 2;
  localparam int C_RXEN  = 3;
  localparam int C_TSTOP = 4;
  localparam int C_TSTRT = 5;
  localparam int C_SRST  = 7;
  localparam int C_RDRES = 8;
  localparam int C_LDCAM = 9;

  localparam logic [DW-1:0] CMD_MASK    = 16'h03BF;
  localparam logic [DW-1:0] CMD_RST_VAL = 16'h0094;
  localparam logic [DW-1:0] DCFG_MASK   = 16'hBFFF;
  localparam logic [DW-1:0] DCFG2_MASK  = 16'hF017;
  localparam logic [DW-1:0] RXCTL_MASK  = 16'hFFE0;
  localparam logic [DW-1:0] TXCTL_MASK  = 16'hF000;
  localparam logic [DW-1:0] IMASK_MASK  = 16'h7FFF;
  localparam logic [DW-1:0] EOB_RST_VAL = 16'h02F8;
  localparam logic [DW-1:0] REV_VAL     = 16'h0004;
  localparam int            ST_EXHAUST  = 5;
endpackage

// File: rtl/nicreg_store.sv
module nicreg_store #(
  parameter int AW = nicreg_pkg::AW,
  parameter int DW = nicreg_pkg::DW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rd <= mem[addr];
  end
endmodule

// File: rtl/nicreg_cmd.sv
module nicreg_cmd
  import nicreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          tx_done,
  input  logic          rra_done,
  input  logic          cam_done,
  output logic [DW-1:0] cr_o,
  output logic [DW-1:0] pulse_o
);
  logic [DW-1:0] cr_q, cr_d;
  logic          release_only;
  logic [DW-1:0] wm;

  assign wm           = wdata & CMD_MASK;
  assign release_only = cr_q[C_SRST] && !wdata[C_SRST];

  always_comb begin
    cr_d = cr_q;
    if (tx_done)  cr_d[C_TX]    = 1'b0;
    if (rra_done) cr_d[C_RDRES] = 1'b0;
    if (cam_done) cr_d[C_LDCAM] = 1'b0;
    if (we) begin
      if (release_only) begin
        cr_d[C_SRST] = 1'b0;
      end else begin
        if (wm[C_SRST]) begin
          cr_d[C_LDCAM] = 1'b0;
          cr_d[C_RDRES] = 1'b0;
          cr_d[C_TX]    = 1'b0;
          cr_d[C_HALT]  = 1'b0;
        end
        cr_d = cr_d | wm;
        if (wm[C_RXDIS]) cr_d[C_RXEN]  = 1'b0;
        if (wm[C_RXEN])  cr_d[C_RXDIS] = 1'b0;
        if (wm[C_TSTOP]) cr_d[C_TSTRT] = 1'b0;
        if (wm[C_TSTRT]) cr_d[C_TSTOP] = 1'b0;
        if (wm[C_SRST])  cr_d[C_RXDIS] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_q    <= CMD_RST_VAL;
      pulse_o <= '0;
    end else begin
      cr_q    <= cr_d;
      pulse_o <= (we && !release_only) ? wm : '0;
    end
  end

  assign cr_o = cr_q;

  // R5: reset-release write only drops the reset bit
  a_r5_release_only: assert property (@(posedge clk) disable iff (rst)
    (we && cr_q[C_SRST] && !wdata[C_SRST]) |=> (pulse_o == '0 && !cr_q[C_SRST]));
  // R8: software reset leaves reset and rx-disable set
  a_r8_swrst_bits: assert property (@(posedge clk) disable iff (rst)
    (we && wdata[C_SRST]) |=> (cr_q[C_SRST] && cr_q[C_RXDIS]));
  // R9: done without a competing write clears the transmit bit
  a_r9_tx_done: assert property (@(posedge clk) disable iff (rst)
    (tx_done && !we) |=> !cr_q[C_TX]);
  // R6: pulses never carry reserved bits
  a_r6_pulse_bits: assert property (@(posedge clk) disable iff (rst)
    (pulse_o & ~CMD_MASK) == '0);
endmodule

// File: rtl/nicreg_istat.sv
module nicreg_istat
  import nicreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we_mask,
  input  logic          we_stat,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] stat_set,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] stat_o,
  output logic          rdres_o,
  output logic          irq_o
);
  logic [DW-1:0] mask_q, stat_q, clr;

  assign clr = we_stat ? (wdata & stat_q) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      stat_q  <= '0;
      rdres_o <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      if (we_mask) mask_q <= wdata & IMASK_MASK;
      stat_q  <= (stat_q & ~clr) | stat_set;
      rdres_o <= clr[ST_EXHAUST];
      irq_o   <= |(mask_q & stat_q);
    end
  end

  assign mask_o = mask_q;
  assign stat_o = stat_q;

  // R2: an empty mask keeps the line low
  a_r2_masked_off: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_o);
  // R3: written ones that were set are gone unless re-raised
  a_r3_w1c: assert property (@(posedge clk) disable iff (rst)
    (we_stat && stat_set == '0) |=> ((stat_q & $past(wdata & stat_q)) == '0));
  // R4: clearing the exhausted bit requests a resource read
  a_r4_rdres: assert property (@(posedge clk) disable iff (rst)
    (we_stat && wdata[ST_EXHAUST] && stat_q[ST_EXHAUST]) |=> rdres_o);
endmodule

// File: rtl/nic_cmd_regfile.sv
module nic_cmd_regfile
  import nicreg_pkg::*;
#(
  parameter int AW_P = nicreg_pkg::AW,
  parameter int DW_P = nicreg_pkg::DW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_we,
  input  logic [AW_P-1:0] host_addr,
  input  logic [DW_P-1:0] host_wdata,
  output logic [DW_P-1:0] host_rdata,
  input  logic            tx_done,
  input  logic            rra_done,
  input  logic            cam_done,
  input  logic [DW_P-1:0] stat_set,
  output logic [DW_P-1:0] cmd_pulse,
  output logic            irq
);
  logic [DW-1:0] cr, imask, istat, cmd_pls;
  logic          rdres;
  logic [DW-1:0] dcfg2_q, eob_q, seq_q, camen_q;
  logic [DW-1:0] spec_val, spec_q, mem_wd, mem_rd;
  logic          is_spec, spec_sel_q, mem_we, in_srst;

  assign in_srst = cr[C_SRST];

  nicreg_cmd u_cmd (
    .clk(clk), .rst(rst),
    .we(host_we && host_addr == A_CMD),
    .wdata(host_wdata),
    .tx_done(tx_done), .rra_done(rra_done), .cam_done(cam_done),
    .cr_o(cr), .pulse_o(cmd_pls)
  );

  nicreg_istat u_ist (
    .clk(clk), .rst(rst),
    .we_mask(host_we && host_addr == A_IMASK),
    .we_stat(host_we && host_addr == A_ISTAT),
    .wdata(host_wdata), .stat_set(stat_set),
    .mask_o(imask), .stat_o(istat), .rdres_o(rdres), .irq_o(irq)
  );

  // registers held in flops, and read-only decode
  always_comb begin
    is_spec  = 1'b1;
    spec_val = '0;
    case (host_addr)
      A_CMD:    spec_val = cr;
      A_IMASK:  spec_val = imask;
      A_ISTAT:  spec_val = istat;
      A_DCFG2:  spec_val = dcfg2_q;
      A_EOB:    spec_val = eob_q;
      A_SEQ:    spec_val = seq_q;
      A_CAMEN:  spec_val = camen_q;
      A_REV:    spec_val = REV_VAL;
      A_ROSTAT: spec_val = '0;
      default: begin
        if (host_addr >= A_CAMP_LO && host_addr <= A_CAMP_HI) spec_val = '0;
        else is_spec = 1'b0;
      end
    endcase
  end

  // write transform for registers kept in the array
  always_comb begin
    mem_wd = host_wdata;
    if (host_addr == A_DCFG)       mem_wd = host_wdata & DCFG_MASK;
    else if (host_addr == A_RXCTL) mem_wd = host_wdata & RXCTL_MASK;
    else if (host_addr == A_TXCTL) mem_wd = host_wdata & TXCTL_MASK;
    else if (host_addr >= A_RING_LO && host_addr <= A_RING_HI)
      mem_wd = {host_wdata[DW-1:1], 1'b0};
    else if (host_addr >= A_TALLY_LO && host_addr <= A_TALLY_HI)
      mem_wd = ~host_wdata;
  end

  assign mem_we = host_we && !is_spec && !(host_addr == A_DCFG && !in_srst);

  nicreg_store #(.AW(AW_P), .DW(DW_P)) u_mem (
    .clk(clk), .we(mem_we), .addr(host_addr), .wd(mem_wd), .rd(mem_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dcfg2_q    <= '0;
      eob_q      <= EOB_RST_VAL;
      seq_q      <= '0;
      camen_q    <= '0;
      spec_q     <= '0;
      spec_sel_q <= 1'b1;
    end else begin
      if (host_we && host_addr == A_DCFG2 && in_srst) dcfg2_q <= host_wdata & DCFG2_MASK;
      if (host_we && host_addr == A_EOB)   eob_q   <= host_wdata;
      if (host_we && host_addr == A_SEQ)   seq_q   <= host_wdata;
      if (host_we && host_addr == A_CAMEN) camen_q <= host_wdata;
      spec_q     <= spec_val;
      spec_sel_q <= is_spec;
    end
  end

  assign host_rdata = spec_sel_q ? spec_q : mem_rd;
  assign cmd_pulse  = cmd_pls | (DW'(rdres) << C_RDRES);

  // R10: the second configuration register is frozen outside reset mode
  a_r10_dcfg2_locked: assert property (@(posedge clk) disable iff (rst)
    (!in_srst) |=> $stable(dcfg2_q));
  // R13: revision reads as a constant
  a_r13_rev_const: assert property (@(posedge clk) disable iff (rst)
    (host_addr == A_REV) |=> (host_rdata == REV_VAL));
endmodule

// File: tb/nic_cmd_regfile_tb.sv
module nic_cmd_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        tx_done = 1'b0, rra_done = 1'b0, cam_done = 1'b0;
  logic [15:0] stat_set = '0;
  logic [15:0] cmd_pulse;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nic_cmd_regfile dut_i (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_done(tx_done), .rra_done(rra_done), .cam_done(cam_done),
    .stat_set(stat_set), .cmd_pulse(cmd_pulse), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // write: inputs set at a falling edge, the state takes them at the next rising edge
  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic rchk(input string req, input logic [5:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic pulse_done(input int which);
    @(negedge clk);
    if (which == 0) tx_done = 1'b1;
    else if (which == 1) rra_done = 1'b1;
    else cam_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0; rra_done = 1'b0; cam_done = 1'b0;
  endtask

  function automatic logic [15:0] model(input logic [5:0] a, input logic [15:0] w);
    if (a == 6'h02) return w & 16'hFFE0;
    if (a == 6'h03) return w & 16'hF000;
    if (a >= 6'h15 && a <= 6'h18) return w & 16'hFFFE;
    if (a >= 6'h2C && a <= 6'h2E) return ~w;
    if ((a >= 6'h22 && a <= 6'h24) || a == 6'h2F) return 16'h0000;
    if (a == 6'h28) return 16'h0004;
    return w;
  endfunction

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual %h expected %h", 16'h0, 16'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    chk("R1 irq", {15'd0, irq}, 16'h0);
    chk("R1 pulse", cmd_pulse, 16'h0);
    rchk("R1 cmd", 6'h00, 16'h0094);
    rchk("R1 mask", 6'h04, 16'h0000);
    rchk("R1 status", 6'h05, 16'h0000);
    rchk("R1 cfg2", 6'h3F, 16'h0000);
    rchk("R1 eob", 6'h13, 16'h02F8);
    rchk("R1 seq", 6'h2B, 16'h0000);
    rchk("R1 camen", 6'h25, 16'h0000);

    // R10 writes accepted in reset mode
    wr(6'h01, 16'hFFFF); rchk("R10 cfg in reset", 6'h01, 16'hBFFF);
    wr(6'h3F, 16'hFFFF); rchk("R10 cfg2 in reset", 6'h3F, 16'hF017);

    // R5 release write: no pulse, only bit 7 drops
    @(negedge clk); host_we = 1'b1; host_addr = 6'h00; host_wdata = 16'h000A;
    @(negedge clk); host_we = 1'b0;
    chk("R5 no pulse", cmd_pulse, 16'h0000);
    rchk("R5 cmd", 6'h00, 16'h0014);

    // R10 writes ignored outside reset mode
    wr(6'h01, 16'h1234); rchk("R10 cfg locked", 6'h01, 16'hBFFF);
    wr(6'h3F, 16'h0000); rchk("R10 cfg2 locked", 6'h3F, 16'hF017);

    // R6 R7 transmit + rx enable; pulse lasts one cycle
    @(negedge clk); host_we = 1'b1; host_addr = 6'h00; host_wdata = 16'h000A;
    @(negedge clk); host_we = 1'b0;
    chk("R6 pulse", cmd_pulse, 16'h000A);
    @(negedge clk);
    chk("R6 pulse one cycle", cmd_pulse, 16'h0000);
    rchk("R7 rxen clears rxdis", 6'h00, 16'h001A);
    pulse_done(0);
    rchk("R9 tx done", 6'h00, 16'h0018);
    wr(6'h00, 16'h0020); rchk("R7 start clears stop", 6'h00, 16'h0028);
    wr(6'h00, 16'h0004); rchk("R7 rxdis clears rxen", 6'h00, 16'h0024);
    // R6 reserved bits masked
    @(negedge clk); host_we = 1'b1; host_addr = 6'h00; host_wdata = 16'hFC40;
    @(negedge clk); host_we = 1'b0;
    chk("R6 reserved pulse", cmd_pulse, 16'h0000);
    rchk("R6 reserved cmd", 6'h00, 16'h0024);
    wr(6'h00, 16'h0300); rchk("R6 rdres+cam", 6'h00, 16'h0324);
    pulse_done(1); rchk("R9 rra done", 6'h00, 16'h0224);
    pulse_done(2); rchk("R9 cam done", 6'h00, 16'h0024);
    // R9 write wins over done in the same cycle
    @(negedge clk); host_we = 1'b1; host_addr = 6'h00; host_wdata = 16'h0002; tx_done = 1'b1;
    @(negedge clk); host_we = 1'b0; tx_done = 1'b0;
    rchk("R9 write wins", 6'h00, 16'h0026);
    // R8 software reset
    wr(6'h00, 16'h0301); wr(6'h00, 16'h0080);
    rchk("R8 swrst", 6'h00, 16'h00A4);
    wr(6'h00, 16'h0000); rchk("R5 release after swrst", 6'h00, 16'h0024);

    // R2 R3 R4 status and interrupt
    @(negedge clk); stat_set = 16'h0065;
    @(negedge clk); stat_set = 16'h0000;
    rchk("R3 set", 6'h05, 16'h0065);
    chk("R2 irq masked", {15'd0, irq}, 16'h0);
    wr(6'h04, 16'hFFFF); rchk("R2 mask bit15", 6'h04, 16'h7FFF);
    chk("R2 irq high", {15'd0, irq}, 16'h1);
    @(negedge clk); host_we = 1'b1; host_addr = 6'h05; host_wdata = 16'h0041;
    @(negedge clk); host_we = 1'b0;
    chk("R4 no rdres", cmd_pulse, 16'h0000);
    rchk("R3 w1c", 6'h05, 16'h0024);
    @(negedge clk); host_we = 1'b1; host_addr = 6'h05; host_wdata = 16'h0020;
    @(negedge clk); host_we = 1'b0;
    chk("R4 rdres pulse", cmd_pulse, 16'h0100);
    @(negedge clk);
    chk("R4 one cycle", cmd_pulse, 16'h0000);
    rchk("R3 after clear", 6'h05, 16'h0004);
    @(negedge clk); host_we = 1'b1; host_addr = 6'h05; host_wdata = 16'h0020;
    @(negedge clk); host_we = 1'b0;
    chk("R4 clear of clear bit", cmd_pulse, 16'h0000);
    @(negedge clk); host_we = 1'b1; host_addr = 6'h05; host_wdata = 16'h0004; stat_set = 16'h0004;
    @(negedge clk); host_we = 1'b0; stat_set = 16'h0000;
    rchk("R3 set wins", 6'h05, 16'h0004);
    wr(6'h04, 16'h0000);
    @(negedge clk);
    chk("R2 irq low", {15'd0, irq}, 16'h0);
    wr(6'h05, 16'hFFFF); rchk("R3 all cleared", 6'h05, 16'h0000);

    // R11 R12 R13 R14 random map sweep
    for (int i = 0; i < 60; i++) begin
      logic [5:0] a;
      logic [15:0] w;
      a = 6'($urandom % 64);
      w = 16'($urandom);
      if (a == 6'h00 || a == 6'h01 || a == 6'h04 || a == 6'h05 || a == 6'h3F) continue;
      wr(a, w);
      rd(a, v);
      chk("R11 R12 R13 R14 map", v, model(a, w));
    end
    wr(6'h03, 16'hFFFF); rchk("R11 txctl", 6'h03, 16'hF000);
    wr(6'h02, 16'hFFFF); rchk("R11 rxctl", 6'h02, 16'hFFE0);
    wr(6'h18, 16'h1235); rchk("R12 ring", 6'h18, 16'h1234);
    wr(6'h2D, 16'h00FF); rchk("R12 tally", 6'h2D, 16'hFF00);
    wr(6'h28, 16'hFFFF); rchk("R13 rev", 6'h28, 16'h0004);
    wr(6'h23, 16'hFFFF); rchk("R13 cam port", 6'h23, 16'h0000);
    wr(6'h2F, 16'hFFFF); rchk("R13 ro", 6'h2F, 16'h0000);
    wr(6'h30, 16'hA5A5); rchk("R14 plain", 6'h30, 16'hA5A5);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule